// File: doc/BRIEF.md
# Status Byte and Service Request Logic

This block builds the 8-bit status byte of an instrument's remote-control status system and raises the request-for-service line. It gathers four summary sources: a standard event register with its enable mask, an operation status register with its enable mask, an output-queue "message available" flag, and a questionable-data summary. From these it forms the status byte and the master summary bit. The master summary bit is the OR of every status bit that software has enabled in the service request enable mask.

A small register port gives software its view of the block. Address 0 holds the service request enable mask, which can be written and read. Address 1 returns the live status byte and is read-only. Reading the status byte clears nothing. The request-for-service output is a single-cycle pulse that fires each time the master summary bit goes from false to true. Bits 0 to 2 are unused. They read as zero in both the status byte and the mask, so they can never cause a request.

Top module: `svc_req_status`

## Requirements
- R1: Status bit 5 is 1 exactly when (esr_bits AND esr_en) has any bit set, and 0 otherwise.
- R2: Status bit 7 is 1 exactly when (osr_bits AND osr_en) has any bit set, and 0 otherwise.
- R3: Status bit 4 follows msg_avail and status bit 3 follows ques_sum, with no delay.
- R4: Status bits 0, 1 and 2 always read 0.
- R5: Status bit 6 (master summary) is the OR over bits 0–5 and 7 of (status byte AND mask). Mask bit 6 has no effect on it.
- R6: A write with reg_we=1 and reg_addr=0 loads reg_wdata into the mask at the next rising clock edge. Reading address 0 returns the mask with bits 0–2 forced to 0. The mask resets to 0.
- R7: Reading address 1 returns the live status byte, including bit 6. Repeated reads return the same value and clear nothing.
- R8: srq is high for exactly one cycle, in the cycle after the first cycle in which the master summary bit is 1 following a cycle in which it was 0. srq stays low while the master summary bit stays 1.
- R9: With mask 48 (bits 4 and 5 enabled), a true bit 3 alone produces no request and leaves bit 6 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| esr_bits | input | ESR_W | Standard event register contents |
| esr_en | input | ESR_W | Standard event enable mask |
| osr_bits | input | OSR_W | Operation status register contents |
| osr_en | input | OSR_W | Operation status enable mask |
| msg_avail | input | 1 | Output queue holds a message |
| ques_sum | input | 1 | Questionable-data summary |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = enable mask, 1 = status byte |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| status_byte | output | 8 | Live status byte |
| srq | output | 1 | Request-for-service pulse |

## Verification
The status byte, the master summary bit and the read data respond to input changes within the same cycle. The bench therefore drives inputs just after the falling edge and compares these outputs a short delay later, before the next rising edge. A mask write takes effect at the following rising edge. srq is registered, so the pulse appears one rising edge after the cycle in which the summary rose. The bench's model computes the expected srq at each edge and compares it just after the next falling edge, before it drives new inputs.

// File: rtl/svc_pkg.sv
package svc_pkg;
  localparam int STB_W   = 8;
  localparam int BIT_QUES = 3;
  localparam int BIT_MAV  = 4;
  localparam int BIT_ESB  = 5;
  localparam int BIT_MSS  = 6;
  localparam int BIT_OSS  = 7;
  localparam int LOW_UNUSED = 3;
  localparam logic [STB_W-1:0] LIVE_MASK = 8'hF8;

  typedef enum logic {
    ADDR_MASK = 1'b0,
    ADDR_STB  = 1'b1
  } reg_addr_e;
endpackage

// File: rtl/any_enabled.sv
module any_enabled #(
  parameter int W = 8
) (
  input  logic [W-1:0] bits,
  input  logic [W-1:0] en,
  output logic         hit
);
  logic [W-1:0] gated;

  for (genvar i = 0; i < W; i++) begin : g_gate
    assign gated[i] = bits[i] & en[i];
  end

  assign hit = |gated;
endmodule

// File: rtl/sre_mask_reg.sv
module sre_mask_reg
  import svc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [STB_W-1:0] wdata,
  output logic [STB_W-1:0] mask
);
  logic [STB_W-1:LOW_UNUSED] mask_q, mask_d;

  always_comb begin
    mask_d = mask_q;
    if (we) mask_d = wdata[STB_W-1:LOW_UNUSED];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  for (genvar i = 0; i < STB_W; i++) begin : g_out
    if (i < LOW_UNUSED) begin : g_zero
      assign mask[i] = 1'b0;
    end else begin : g_live
      assign mask[i] = mask_q[i];
    end
  end

  a_r6_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    mask[LOW_UNUSED-1:0] == '0);
  a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mask == ($past(wdata) & LIVE_MASK)));
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mask));
endmodule

// File: rtl/srq_edge.sv
module srq_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic pulse
);
  logic level_q, pulse_q, pulse_d;

  always_comb pulse_d = level & ~level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      level_q <= level;
      pulse_q <= pulse_d;
    end
  end

  assign pulse = pulse_q;

  a_r8_rise_fires: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(level) |=> pulse);
  a_r8_needs_level: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> $past(level));
  a_r8_single: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
endmodule

// File: rtl/svc_req_status.sv
module svc_req_status
  import svc_pkg::*;
#(
  parameter int ESR_W = 8,
  parameter int OSR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ESR_W-1:0] esr_bits,
  input  logic [ESR_W-1:0] esr_en,
  input  logic [OSR_W-1:0] osr_bits,
  input  logic [OSR_W-1:0] osr_en,
  input  logic             msg_avail,
  input  logic             ques_sum,
  input  logic             reg_we,
  input  logic             reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic [7:0]       status_byte,
  output logic             srq
);
  logic [1:0]       rst_sync;
  logic             rst_int_n;
  logic             esb, oss, mss;
  logic [STB_W-1:0] stb_raw, mask, masked;
  logic             mask_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  any_enabled #(.W(ESR_W)) u_esb (.bits(esr_bits), .en(esr_en), .hit(esb));
  any_enabled #(.W(OSR_W)) u_oss (.bits(osr_bits), .en(osr_en), .hit(oss));

  assign mask_we = reg_we && (reg_addr == ADDR_MASK);

  sre_mask_reg u_mask (
    .clk  (clk),
    .rst_n(rst_int_n),
    .we   (mask_we),
    .wdata(reg_wdata),
    .mask (mask)
  );

  always_comb begin
    stb_raw           = '0;
    stb_raw[BIT_QUES] = ques_sum;
    stb_raw[BIT_MAV]  = msg_avail;
    stb_raw[BIT_ESB]  = esb;
    stb_raw[BIT_OSS]  = oss;
    masked            = stb_raw & mask;
    masked[BIT_MSS]   = 1'b0;
    mss               = |masked;
    status_byte       = stb_raw;
    status_byte[BIT_MSS] = mss;
  end

  always_comb begin
    if (reg_addr == ADDR_STB) reg_rdata = status_byte;
    else                      reg_rdata = mask;
  end

  srq_edge u_srq (
    .clk  (clk),
    .rst_n(rst_int_n),
    .level(mss),
    .pulse(srq)
  );

  a_r4_low_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    status_byte[2:0] == 3'b000);
  a_r5_no_mask_no_mss: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mask == 8'h00) |-> !status_byte[BIT_MSS]);
  a_r9_idle_mask_quiet: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mask == 8'h00 && $past(mask) == 8'h00) |-> !srq);
  a_r7_read_live: assert property (@(posedge clk) disable iff (!rst_int_n)
    (reg_addr == ADDR_STB) |-> (reg_rdata == status_byte));
endmodule

// File: tb/svc_req_status_tb.sv
module svc_req_status_tb;
  localparam int ESR_W = 8;
  localparam int OSR_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [ESR_W-1:0] esr_bits = '0, esr_en = '0;
  logic [OSR_W-1:0] osr_bits = '0, osr_en = '0;
  logic             msg_avail = 1'b0, ques_sum = 1'b0;
  logic             reg_we = 1'b0, reg_addr = 1'b0;
  logic [7:0]       reg_wdata = '0;
  logic [7:0]       reg_rdata, status_byte;
  logic             srq;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_mask = 8'h00;
  logic       m_mss_prev = 1'b0;
  logic       m_srq = 1'b0;

  always #5 clk = ~clk;

  svc_req_status #(.ESR_W(ESR_W), .OSR_W(OSR_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .esr_bits(esr_bits), .esr_en(esr_en),
    .osr_bits(osr_bits), .osr_en(osr_en),
    .msg_avail(msg_avail), .ques_sum(ques_sum),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .status_byte(status_byte), .srq(srq)
  );

  function automatic logic [7:0] exp_raw();
    logic [7:0] s = 8'h00;
    s[5] = |(esr_bits & esr_en);
    s[7] = |(osr_bits & osr_en);
    s[4] = msg_avail;
    s[3] = ques_sum;
    return s;
  endfunction

  function automatic logic exp_mss(input logic [7:0] raw, input logic [7:0] msk);
    return |(raw & msk & 8'hBF);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step(input logic [ESR_W-1:0] eb, input logic [ESR_W-1:0] ee,
                      input logic [OSR_W-1:0] ob, input logic [OSR_W-1:0] oe,
                      input logic mav, input logic qs,
                      input logic we, input logic ad, input logic [7:0] wd);
    logic [7:0] raw, exp_stb;
    logic       mss_now;
    @(negedge clk);
    chk("R8 srq", {7'd0, srq}, {7'd0, m_srq});
    esr_bits = eb; esr_en = ee; osr_bits = ob; osr_en = oe;
    msg_avail = mav; ques_sum = qs;
    reg_we = we; reg_addr = ad; reg_wdata = wd;
    #1;
    raw = exp_raw();
    mss_now = exp_mss(raw, m_mask);
    exp_stb = raw | {1'b0, mss_now, 6'd0};
    chk("R1 R2 R3 R4 R5 status", status_byte, exp_stb);
    chk(ad ? "R7 read stb" : "R6 read mask", reg_rdata, ad ? exp_stb : m_mask);
    m_srq = mss_now & ~m_mss_prev;
    m_mss_prev = mss_now;
    if (we && !ad) m_mask = wd & 8'hF8;
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // reset state: mask and status zero
    chk("R6 reset mask", reg_rdata, 8'h00);
    chk("R4 reset stb", status_byte, 8'h00);
    chk("R8 reset srq", {7'd0, srq}, 8'h00);

    // R1 masked vs enabled events
    step(8'hA5, 8'h00, '0, '0, 0, 0, 0, 1, 0);
    step(8'hA5, 8'h04, '0, '0, 0, 0, 0, 1, 0);
    // R2 operation summary
    step('0, '0, 16'h8000, 16'h7FFF, 0, 0, 0, 1, 0);
    step('0, '0, 16'h8000, 16'h8000, 0, 0, 0, 1, 0);
    // R6 write 0xFF reads back 0xF8
    step('0, '0, '0, '0, 0, 0, 1, 0, 8'hFF);
    step('0, '0, '0, '0, 0, 0, 0, 0, 0);
    chk("R6 readback low zero", reg_rdata, 8'hF8);
    // R9 mask 48, bit 3 alone gives no request
    step('0, '0, '0, '0, 0, 0, 1, 0, 8'd48);
    step('0, '0, '0, '0, 0, 1, 0, 1, 0);
    step('0, '0, '0, '0, 0, 1, 0, 1, 0);
    chk("R9 no mss from bit3", {7'd0, status_byte[6]}, 8'h00);
    // R8 message available raises request once, then holds
    step('0, '0, '0, '0, 1, 1, 0, 1, 0);
    step('0, '0, '0, '0, 1, 1, 0, 1, 0);
    chk("R8 pulse", {7'd0, srq}, 8'h01);
    step('0, '0, '0, '0, 1, 1, 0, 1, 0);
    chk("R8 one cycle", {7'd0, srq}, 8'h00);
    // R7 repeated reads unchanged
    chk("R7 no clear", reg_rdata, 8'h58);
    step('0, '0, '0, '0, 1, 1, 0, 1, 0);
    chk("R7 repeat read", reg_rdata, 8'h58);
    // R5 mask bit 6 only has no effect
    step('0, '0, '0, '0, 1, 1, 1, 0, 8'h40);
    step(8'hFF, 8'hFF, 16'hFFFF, 16'hFFFF, 1, 1, 0, 1, 0);
    chk("R5 mask bit6 ignored", {7'd0, status_byte[6]}, 8'h00);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic sparse;
      sparse = ($urandom % 3) == 0;
      step(ESR_W'($urandom) & (sparse ? ESR_W'($urandom) : '0), ESR_W'($urandom),
           OSR_W'($urandom) & (sparse ? OSR_W'($urandom) : '0), OSR_W'($urandom),
           ($urandom % 4) == 0, ($urandom % 4) == 0,
           ($urandom % 8) == 0, 1'($urandom), 8'($urandom));
    end
    @(negedge clk);
    chk("R8 final srq", {7'd0, srq}, {7'd0, m_srq});
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule